// File: doc/BRIEF.md
# Adaptive Delta Modulation Encoder

This block turns a stream of signed multi-bit samples into a one-bit delta-modulated stream. A sample is taken on each cycle where the sample-enable input is high. The block compares the sample against an internal reconstruction of the signal and emits a single decision bit. It then moves the reconstruction up or down by the current step size. The reconstruction is a saturating accumulator. It is also driven out so that a downstream decoder, or a check of the loop, can see the exact value that the bit stream encodes.

The step size adapts to the recent decisions. A run of identical decisions means the loop is falling behind a steep input, so the step grows. A change of direction means the loop is hunting around the input, so the step shrinks. The base, lower and upper step limits come from configuration inputs. An optional pseudo-random dither, taken from an on-chip shift-register sequence, can be added to the input before the comparison. The dither breaks up the idle patterns that a constant input would otherwise produce.

Top module: `adm_encoder`

## Requirements
- R1: Each accepted sample produces exactly one decision bit: 1 when the (possibly dithered) sample is strictly greater than the current reconstruction, and 0 when it is equal or smaller.
- R2: On each accepted sample the reconstruction increases by the current step after a 1 decision and decreases by it after a 0 decision. `recon_out` shows the updated value in the same cycle that `bit_out` shows the decision.
- R3: The reconstruction saturates at the most positive code (2047 at the default width) and at the most negative code (-2048); it never wraps.
- R4: When the four newest decisions (counting the current one, and at least four since reset) are all 1 or all 0, the step used for the next sample doubles, limited to `cfg_max_step`.
- R5: When the current decision differs from the previous one, the step for the next sample halves (shift right by one), limited below by `cfg_min_step`.
- R6: Reset (active-low `rst_n`) sets the reconstruction to 0, the step to `cfg_base_step`, `bit_out` and `bit_valid` to 0, clears the decision history, and loads the dither sequence with 16'hACE1.
- R7: With `cfg_dither_en` high, the low two bits of the 16-bit sequence register, read as a signed two-bit value (-2..1), are added to the sample before the comparison. The sequence shifts left once per accepted sample whether or not dither is enabled, and the new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10.
- R8: State changes only on cycles with `sample_en` high. `bit_valid` is high for exactly the one cycle after each accepted sample. With `sample_en` low, changes on `sample_in` leave `recon_out` unchanged.
- R9: With a constant input and dither disabled, the stream settles into alternating 1 and 0 decisions, with the reconstruction moving by exactly `cfg_min_step` each sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_en | input | 1 | Accept `sample_in` this cycle |
| sample_in | input | DW (12) | Signed input sample |
| cfg_base_step | input | SW (11) | Step loaded at reset |
| cfg_min_step | input | SW (11) | Lower step limit |
| cfg_max_step | input | SW (11) | Upper step limit |
| cfg_dither_en | input | 1 | Add pseudo-random dither before the comparison |
| bit_out | output | 1 | Registered decision bit |
| bit_valid | output | 1 | One-cycle strobe for `bit_out` |
| recon_out | output | DW (12) | Signed reconstruction after the last update |

## Verification
A wrong step or a wrong history bit does not show in the decision at once. It shows in the size of the very next change of `recon_out`, one cycle after the following accepted sample. A corrupted accumulator shows on `recon_out` in the same strobe cycle. A wrong dither sequence shifts decisions only where the sample lies within two codes of the reconstruction. For that reason the bench compares every strobe, bit and reconstruction together, against a reference model over long runs with dither on. Saturation, idle cycles and the settling of a constant input are each exercised on their own.

// File: rtl/adm_pkg.sv
package adm_pkg;
  localparam int LFSR_W = 16;

  typedef enum logic [1:0] {
    STEP_KEEP   = 2'd0,
    STEP_DOUBLE = 2'd1,
    STEP_HALVE  = 2'd2
  } step_act_e;

  // x^16 + x^14 + x^13 + x^11 + 1, shifted left, feedback into bit 0
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/adm_lfsr.sv
module adm_lfsr
  import adm_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (adv) state_d = lfsr_advance(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  a_r7_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q));
endmodule

// File: rtl/adm_step_ctrl.sv
module adm_step_ctrl
  import adm_pkg::*;
#(
  parameter int SW   = 11,
  parameter int HIST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dec,
  input  logic [SW-1:0] base_step,
  input  logic [SW-1:0] min_step,
  input  logic [SW-1:0] max_step,
  output logic [SW-1:0] step
);
  localparam int CW = $clog2(HIST + 1);
  localparam logic [CW-1:0] RUN_CNT  = CW'(HIST - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(HIST);

  logic [SW-1:0]   step_q, step_d;
  logic [HIST-1:0] hist_q, hist_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [SW:0]     dbl_w;
  logic [SW-1:0]   dbl_clamped, half_clamped;
  logic            run_hit, flip_hit;
  step_act_e       act;

  always_comb begin
    hist_d   = {hist_q[HIST-2:0], dec};
    run_hit  = (cnt_q >= RUN_CNT) && ((&hist_d) || (~|hist_d));
    flip_hit = (cnt_q != '0) && (dec != hist_q[0]);
    if (run_hit)       act = STEP_DOUBLE;
    else if (flip_hit) act = STEP_HALVE;
    else               act = STEP_KEEP;

    dbl_w        = {step_q, 1'b0};
    dbl_clamped  = (dbl_w > {1'b0, max_step}) ? max_step : dbl_w[SW-1:0];
    half_clamped = ((step_q >> 1) < min_step) ? min_step : (step_q >> 1);
  end

  always_comb begin
    step_d = step_q;
    cnt_d  = cnt_q;
    if (en) begin
      unique case (act)
        STEP_DOUBLE: step_d = dbl_clamped;
        STEP_HALVE:  step_d = half_clamped;
        default:     step_d = step_q;
      endcase
      if (cnt_q != FULL_CNT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= base_step;
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      step_q <= step_d;
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
    end
  end

  assign step = step_q;

  a_r8_step_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(step_q));
  a_r4_double: assert property (@(posedge clk) disable iff (!rst_n)
    en && run_hit && (dbl_w <= {1'b0, max_step}) |=> step_q == ($past(step_q) << 1));
  a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    en && run_hit |=> step_q <= $past(max_step));
  a_r5_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    en && flip_hit && (step_q >= min_step) |=> step_q <= $past(step_q));
endmodule

// File: rtl/adm_integrator.sv
module adm_integrator #(
  parameter int DW = 12,
  parameter int SW = DW - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] smp,
  input  logic signed [1:0]    dith,
  input  logic        [SW-1:0] step,
  output logic                 dec,
  output logic signed [DW-1:0] acc,
  output logic                 bit_q,
  output logic                 vld_q
);
  localparam logic signed [DW:0] ACC_MAX = {2'b00, {(DW-1){1'b1}}};
  localparam logic signed [DW:0] ACC_MIN = {2'b11, {(DW-1){1'b0}}};

  logic signed [DW-1:0] acc_q, acc_d;
  logic signed [DW:0]   cmp_in, acc_ext, step_ext, sum;
  logic                 bit_d;

  always_comb begin
    cmp_in   = {smp[DW-1], smp} + {{(DW-1){dith[1]}}, dith};
    acc_ext  = {acc_q[DW-1], acc_q};
    step_ext = {{(DW+1-SW){1'b0}}, step};
    dec      = cmp_in > acc_ext;
    sum      = dec ? (acc_ext + step_ext) : (acc_ext - step_ext);
    if (sum > ACC_MAX)      acc_d = ACC_MAX[DW-1:0];
    else if (sum < ACC_MIN) acc_d = ACC_MIN[DW-1:0];
    else                    acc_d = sum[DW-1:0];
    bit_d = en ? dec : bit_q;
    if (!en) acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      bit_q <= bit_d;
      vld_q <= en;
    end
  end

  assign acc = acc_q;

  a_r3_up_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    en && dec |=> acc_q >= $past(acc_q));
  a_r3_down_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    en && !dec |=> acc_q <= $past(acc_q));
  a_r8_valid_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> vld_q);
  a_r8_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !vld_q);
  a_r8_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/adm_encoder.sv
module adm_encoder
  import adm_pkg::*;
#(
  parameter int                DW        = 12,
  parameter int                SW        = DW - 1,
  parameter int                HIST      = 4,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic [DW-1:0] sample_in,
  input  logic [SW-1:0] cfg_base_step,
  input  logic [SW-1:0] cfg_min_step,
  input  logic [SW-1:0] cfg_max_step,
  input  logic          cfg_dither_en,
  output logic          bit_out,
  output logic          bit_valid,
  output logic [DW-1:0] recon_out
);
  logic [LFSR_W-1:0]    lfsr_state;
  logic signed [1:0]    dith;
  logic [SW-1:0]        step;
  logic                 dec;
  logic signed [DW-1:0] acc;

  adm_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (sample_en),
    .state (lfsr_state)
  );

  assign dith = cfg_dither_en ? $signed(lfsr_state[1:0]) : 2'sb00;

  adm_integrator #(.DW(DW), .SW(SW)) u_integ (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sample_en),
    .smp   ($signed(sample_in)),
    .dith  (dith),
    .step  (step),
    .dec   (dec),
    .acc   (acc),
    .bit_q (bit_out),
    .vld_q (bit_valid)
  );

  adm_step_ctrl #(.SW(SW), .HIST(HIST)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (sample_en),
    .dec       (dec),
    .base_step (cfg_base_step),
    .min_step  (cfg_min_step),
    .max_step  (cfg_max_step),
    .step      (step)
  );

  assign recon_out = acc;

  a_r2_step_move: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && (acc != {1'b0, {(DW-1){1'b1}}}) && (acc != {1'b1, {(DW-1){1'b0}}})
      && (step != '0) |=> recon_out != $past(recon_out));
endmodule

// File: tb/adm_encoder_tb.sv
module adm_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int SW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sample_en;
  logic [DW-1:0] sample_in;
  logic [SW-1:0] cfg_base_step, cfg_min_step, cfg_max_step;
  logic          cfg_dither_en;
  logic          bit_out, bit_valid;
  logic [DW-1:0] recon_out;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adm_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample_in(sample_in),
    .cfg_base_step(cfg_base_step), .cfg_min_step(cfg_min_step),
    .cfg_max_step(cfg_max_step), .cfg_dither_en(cfg_dither_en),
    .bit_out(bit_out), .bit_valid(bit_valid), .recon_out(recon_out)
  );

  // reference model state
  int          m_acc, m_step, m_cnt;
  logic [3:0]  m_hist;
  logic [15:0] m_lfsr;
  bit          exp_bit[$];
  int          exp_rec[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = 0; m_step = int'(cfg_base_step); m_cnt = 0; m_hist = '0; m_lfsr = 16'hACE1;
  endtask

  task automatic model_step(input int x);
    int d, xi, na;
    bit dec;
    logic [3:0] nh;
    d   = cfg_dither_en ? int'($signed(m_lfsr[1:0])) : 0;
    xi  = x + d;
    dec = xi > m_acc;
    na  = dec ? m_acc + m_step : m_acc - m_step;
    if (na > 2047) na = 2047;
    if (na < -2048) na = -2048;
    nh = {m_hist[2:0], dec};
    if (m_cnt >= 3 && (nh == 4'hF || nh == 4'h0)) begin
      m_step = m_step * 2;
      if (m_step > int'(cfg_max_step)) m_step = int'(cfg_max_step);
    end else if (m_cnt >= 1 && dec != m_hist[0]) begin
      m_step = m_step / 2;
      if (m_step < int'(cfg_min_step)) m_step = int'(cfg_min_step);
    end
    if (m_cnt < 4) m_cnt++;
    m_hist = nh;
    m_acc  = na;
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    exp_bit.push_back(dec);
    exp_rec.push_back(na);
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic drive(input int x);
    sample_en = 1'b1;
    sample_in = DW'(x);
    model_step(x);
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && bit_valid) begin
      if (exp_bit.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", 1, 0);
      end else begin
        bit eb;
        int er;
        eb = exp_bit.pop_front();
        er = exp_rec.pop_front();
        check(bit_out == eb, "R1 decision bit", int'(bit_out), int'(eb));
        check(int'($signed(recon_out)) == er, "R2/R3/R4/R5/R7 reconstruction",
              int'($signed(recon_out)), er);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    @(negedge clk);
    exp_bit.delete(); exp_rec.delete();
    check(bit_valid == 1'b0, "R6 valid at reset", int'(bit_valid), 0);
    check(bit_out == 1'b0, "R6 bit at reset", int'(bit_out), 0);
    check(recon_out == '0, "R6 recon at reset", int'($signed(recon_out)), 0);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int prev_b, prev_r, hold_r, max_seen;
    bit alt_ok, mag_ok;
    sample_en = 1'b0; sample_in = '0;
    cfg_base_step = 11'd8; cfg_min_step = 11'd1; cfg_max_step = 11'd256;
    cfg_dither_en = 1'b0;
    do_reset();

    // R6/R2: first sample after reset moves by base step
    drive(100);
    check(int'($signed(recon_out)) == 8, "R6 base step after reset", int'($signed(recon_out)), 8);
    check(bit_valid == 1'b1, "R8 strobe after sample", int'(bit_valid), 1);

    // R8: idle cycles with a changing input have no effect
    hold_r = int'($signed(recon_out));
    sample_in = 12'h7F0;
    @(negedge clk);
    sample_in = 12'h800;
    @(negedge clk);
    check(bit_valid == 1'b0, "R8 no strobe while idle", int'(bit_valid), 0);
    check(int'($signed(recon_out)) == hold_r, "R8 recon held while idle",
          int'($signed(recon_out)), hold_r);

    // R4: ramp forcing runs (back-to-back samples)
    for (int i = 0; i < 40; i++) drive(100 + i*40);
    // R5: oscillating input forcing flips
    for (int i = 0; i < 40; i++) drive((i % 2) ? 300 : -300);

    // R7: dithered random-ish input, spaced and back-to-back
    cfg_dither_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      drive(((i * 37) % 200) - 100);
      if (i % 5 == 0) @(negedge clk);
    end
    for (int i = 0; i < 100; i++) drive(int'($signed(recon_out)));
    cfg_dither_en = 1'b0;

    // R3: positive saturation
    cfg_base_step = 11'd200; cfg_max_step = 11'd1024;
    do_reset();
    max_seen = -5000;
    for (int i = 0; i < 30; i++) begin
      drive(2047);
      if (int'($signed(recon_out)) > max_seen) max_seen = int'($signed(recon_out));
    end
    check(max_seen == 2047, "R3 top clamp reached", max_seen, 2047);
    // R3: negative saturation
    for (int i = 0; i < 30; i++) drive(-2048);
    check(int'($signed(recon_out)) == -2048, "R3 bottom clamp", int'($signed(recon_out)), -2048);
    check(bit_out == 1'b0, "R1 equal gives zero", int'(bit_out), 0);

    // R9: constant input settles to alternating at min step
    cfg_base_step = 11'd64; cfg_min_step = 11'd1; cfg_max_step = 11'd256;
    do_reset();
    for (int i = 0; i < 80; i++) drive(100);
    prev_b = int'(bit_out); prev_r = int'($signed(recon_out));
    alt_ok = 1'b1; mag_ok = 1'b1;
    for (int i = 0; i < 10; i++) begin
      drive(100);
      if (int'(bit_out) == prev_b) alt_ok = 1'b0;
      if ((int'($signed(recon_out)) - prev_r) != 1 && (prev_r - int'($signed(recon_out))) != 1)
        mag_ok = 1'b0;
      prev_b = int'(bit_out); prev_r = int'($signed(recon_out));
    end
    check(alt_ok, "R9 alternating bits", int'(alt_ok), 1);
    check(mag_ok, "R9 min step movement", int'(mag_ok), 1);

    // R9 with a larger minimum step
    cfg_min_step = 11'd4;
    do_reset();
    for (int i = 0; i < 80; i++) drive(-333);
    prev_r = int'($signed(recon_out));
    drive(-333);
    check((int'($signed(recon_out)) - prev_r == 4) || (prev_r - int'($signed(recon_out)) == 4),
          "R9 settled step equals minimum", int'($signed(recon_out)) - prev_r, 4);

    @(negedge clk);
    check(exp_bit.size() == 0, "R8 every sample strobed", exp_bit.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule